// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a bank of token flags that two processor ports, left and right, use to claim and release shared resources without contention. Each port has its own select, write strobe, output enable, address and data pins. Both ports run on one clock. A write happens in every cycle in which the port's select and write strobe are both high. Bit 0 of the write data goes into that port's request latch for the addressed flag: 0 requests the token and 1 releases it. Cross-coupled ownership logic grants each flag to at most one side. A request from the side that does not own the flag waits in its latch, and the flag moves to that side when the owner releases it.

A read returns the flag as that port sees it, copied into every data bit. A port reads 0 when it owns the flag and 1 otherwise. The value is frozen from the first cycle in which select and output enable are both high until one of them drops, so a read can never tear. The interface is a register-style control port with no valid/ready handshake and no back-pressure. A read completes in the cycle it is presented, and a write completes at the next clock edge.

Top module: `sem_bank`

## Requirements
- R1: There are NFLAG (default 8) flags, chosen by address bits [2:0]. All higher address bits are ignored on both writes and reads.
- R2: A write uses only data bit 0: 0 requests the flag and 1 releases it. All other data bits have no effect.
- R3: After a side writes 0 to a free flag, from the next cycle that side reads all zeros and the other side reads all ones.
- R4: A 0 written by the non-owning side is held as a pending request. The owner keeps the flag, and the requester keeps reading all ones.
- R5: When the owner writes 1 while the other side has a pending request, the flag passes to the waiting side at that clock edge. The new owner then reads all zeros and the old owner reads all ones.
- R6: When the owner writes 1 and no request is pending, the flag becomes free and both sides read all ones.
- R7: A read returns the port's view of the flag replicated into all DATA_W bits: 16'hFFFF for 1 and 16'h0000 for 0.
- R8: The read value is taken in the first cycle in which select and output enable are both high. It stays unchanged until one of them goes low, even if the other port changes the flag or the address changes.
- R9: If both sides write 0 to a free flag in the same cycle, the left side wins and the right side's request stays pending.
- R10: Synchronous reset sets every request latch on both sides to 1, so all flags are free. Writing 1 from both sides also frees a flag whose two latches both hold 0.
- R11: A write strobe while select is low has no effect.
- R12: The read data is zero and the read-drive indicator is low unless select and output enable are both high.
- R13: A side that writes 1 to withdraw its pending request does not receive the flag when the owner later releases it; the flag becomes free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left semaphore select |
| l_wr | input | 1 | Left write strobe |
| l_oe | input | 1 | Left output enable |
| l_addr | input | ADDR_W | Left address; only bits [2:0] are used |
| l_wdata | input | DATA_W | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left read data, replicated flag view |
| l_rdrive | output | 1 | High while left read data is driven |
| r_sel | input | 1 | Right semaphore select |
| r_wr | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W | Right address; only bits [2:0] are used |
| r_wdata | input | DATA_W | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right read data, replicated flag view |
| r_rdrive | output | 1 | High while right read data is driven |

## Verification
The bench uses the default parameters: NFLAG=8, ADDR_W=14 and DATA_W=16. The 14-bit address lets writes and reads carry ones in the ignored upper bits. The 16-bit data bus shows that replication fills every bit and that only bit 0 of a write counts. With two independent port drivers the bench can create same-cycle claims, a handover during a frozen read, and release with both latches pending.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_LEFT  = 2'd1,
    HOLD_RIGHT = 2'd2
  } holder_e;

endpackage

// File: rtl/sem_flag.sv
module sem_flag
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic l_we,
  input  logic l_bit,
  input  logic r_we,
  input  logic r_bit,
  output logic l_view,
  output logic r_view
);

  logic    l_req_q, r_req_q;
  logic    l_req_n, r_req_n;
  holder_e hold_q, hold_n;

  // request latches: 0 = requesting, 1 = idle
  assign l_req_n = l_we ? l_bit : l_req_q;
  assign r_req_n = r_we ? r_bit : r_req_q;

  always_comb begin
    hold_n = hold_q;
    unique case (hold_q)
      HOLD_LEFT: begin
        if (l_req_n) hold_n = r_req_n ? HOLD_NONE : HOLD_RIGHT;
      end
      HOLD_RIGHT: begin
        if (r_req_n) hold_n = l_req_n ? HOLD_NONE : HOLD_LEFT;
      end
      default: begin
        // left takes precedence on a same-cycle claim
        if (!l_req_n)      hold_n = HOLD_LEFT;
        else if (!r_req_n) hold_n = HOLD_RIGHT;
        else               hold_n = HOLD_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_req_q <= 1'b1;
      r_req_q <= 1'b1;
      hold_q  <= HOLD_NONE;
    end else begin
      l_req_q <= l_req_n;
      r_req_q <= r_req_n;
      hold_q  <= hold_n;
    end
  end

  assign l_view = (hold_q != HOLD_LEFT);
  assign r_view = (hold_q != HOLD_RIGHT);

  AST_OWNER_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!l_view && !(l_we && l_bit)) |=> !l_view); // R4
  AST_HANDOVER: assert property (@(posedge clk) disable iff (rst)
    (!l_view && l_we && l_bit && !r_req_q && !(r_we && r_bit)) |=> (!r_view && l_view)); // R5
  AST_RELEASE_FREE: assert property (@(posedge clk) disable iff (rst)
    (!l_view && l_we && l_bit && r_req_q && !(r_we && !r_bit)) |=> (l_view && r_view)); // R6
  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (rst)
    (l_view && r_view && l_we && !l_bit && r_we && !r_bit) |=> (!l_view && r_view)); // R9

endmodule

// File: rtl/sem_port.sv
module sem_port #(
  parameter int NFLAG  = 8,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  localparam int IDX_W = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NFLAG-1:0]  view,
  output logic [NFLAG-1:0]  wr_hit,
  output logic              wr_bit,
  output logic [DATA_W-1:0] rdata,
  output logic              rdrive
);

  logic [IDX_W-1:0] idx;
  logic             act, act_q;
  logic             live;
  logic             held_q;

  assign idx    = addr[IDX_W-1:0];
  assign wr_bit = wdata[0];

  for (genvar i = 0; i < NFLAG; i++) begin : g_dec
    assign wr_hit[i] = sel && wr && (idx == IDX_W'(i));
  end

  assign act  = sel && oe;
  assign live = view[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      held_q <= 1'b1;
    end else begin
      act_q <= act;
      if (act && !act_q) held_q <= live;
    end
  end

  always_comb begin
    if (!act)       rdata = '0;
    else if (act_q) rdata = {DATA_W{held_q}};
    else            rdata = {DATA_W{live}};
  end

  assign rdrive = act;

  AST_READ_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (act && act_q) |-> $stable(rdata)); // R8
  AST_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !act |-> (rdata == '0 && !rdrive)); // R12
  AST_READ_REPL: assert property (@(posedge clk) disable iff (rst)
    act |-> (rdata == '0 || rdata == '1)); // R7

endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NFLAG  = 8,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rdrive,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rdrive
);

  logic [NFLAG-1:0] l_hit, r_hit;
  logic [NFLAG-1:0] l_view, r_view;
  logic             l_bit, r_bit;

  sem_port #(.NFLAG(NFLAG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lport (
    .clk(clk), .rst(rst), .sel(l_sel), .wr(l_wr), .oe(l_oe),
    .addr(l_addr), .wdata(l_wdata), .view(l_view),
    .wr_hit(l_hit), .wr_bit(l_bit), .rdata(l_rdata), .rdrive(l_rdrive)
  );

  sem_port #(.NFLAG(NFLAG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rport (
    .clk(clk), .rst(rst), .sel(r_sel), .wr(r_wr), .oe(r_oe),
    .addr(r_addr), .wdata(r_wdata), .view(r_view),
    .wr_hit(r_hit), .wr_bit(r_bit), .rdata(r_rdata), .rdrive(r_rdrive)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    sem_flag u_flag (
      .clk(clk), .rst(rst),
      .l_we(l_hit[i]), .l_bit(l_bit),
      .r_we(r_hit[i]), .r_bit(r_bit),
      .l_view(l_view[i]), .r_view(r_view[i])
    );
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    (~l_view & ~r_view) == '0); // R3

endmodule

// File: tb/sem_bank_test.sv
`timescale 1ns/1ps
module sem_bank_test;

  localparam int AW = 14;
  localparam int DW = 16;
  localparam logic [DW-1:0] ONES = 16'hFFFF;
  localparam logic [DW-1:0] ZERO = 16'h0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          l_sel = 0, l_wr = 0, l_oe = 0;
  logic [AW-1:0] l_addr = '0;
  logic [DW-1:0] l_wdata = '0;
  logic [DW-1:0] l_rdata;
  logic          l_rdrive;
  logic          r_sel = 0, r_wr = 0, r_oe = 0;
  logic [AW-1:0] r_addr = '0;
  logic [DW-1:0] r_wdata = '0;
  logic [DW-1:0] r_rdata;
  logic          r_rdrive;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sem_bank #(.NFLAG(8), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rdrive(l_rdrive),
    .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rdrive(r_rdrive)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write cycle on either or both sides; side bits enable each port
  task automatic wr2(input bit le, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                     input bit re, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
    @(negedge clk);
    l_sel = le; l_wr = le; l_addr = la; l_wdata = ld;
    r_sel = re; r_wr = re; r_addr = ra; r_wdata = rd;
    @(negedge clk);
    l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
  endtask

  task automatic wl(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr2(1, a, d, 0, '0, '0);
  endtask

  task automatic wrt(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr2(0, '0, '0, 1, a, d);
  endtask

  task automatic rd(input bit right, input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    if (right) begin r_sel = 1; r_oe = 1; r_addr = a; end
    else       begin l_sel = 1; l_oe = 1; l_addr = a; end
    #1;
    v = right ? r_rdata : l_rdata;
    @(negedge clk);
    l_sel = 0; l_oe = 0; r_sel = 0; r_oe = 0;
  endtask

  task automatic expect_views(input string req, input logic [AW-1:0] a,
                              input logic [DW-1:0] le, input logic [DW-1:0] re);
    logic [DW-1:0] v;
    rd(0, a, v); chk({req, " left"}, v, le);
    rd(1, a, v); chk({req, " right"}, v, re);
  endtask

  task automatic t_reset;
    for (int f = 0; f < 8; f++) expect_views("R10 reset free", AW'(f), ONES, ONES);
    #1;
    chk("R12 idle rdata left", l_rdata, ZERO);
    chk("R12 idle rdrive", {15'd0, l_rdrive | r_rdrive}, ZERO);
  endtask

  task automatic t_claim;
    wl(14'd1, 16'h0000);
    expect_views("R3 R7 claim", 14'd1, ZERO, ONES);
  endtask

  task automatic t_pending;
    wrt(14'd1, 16'h0000);
    expect_views("R4 pending", 14'd1, ZERO, ONES);
    wl(14'd1, 16'h0001);
    expect_views("R5 handover", 14'd1, ONES, ZERO);
    wrt(14'd1, 16'h0001);
    expect_views("R6 release free", 14'd1, ONES, ONES);
  endtask

  task automatic t_addr;
    wl(14'h3FFD, 16'hFFFE);
    expect_views("R1 R2 high bits ignored", 14'h0005, ZERO, ONES);
    expect_views("R1 alias read", 14'h2A85, ZERO, ONES);
    expect_views("R1 neighbour untouched", 14'd4, ONES, ONES);
    wl(14'h0005, 16'hAAAB);
    expect_views("R2 release bit0 only", 14'd5, ONES, ONES);
  endtask

  task automatic t_nosel;
    @(negedge clk);
    l_sel = 0; l_wr = 1; l_addr = 14'd2; l_wdata = 16'h0000;
    r_sel = 0; r_wr = 1; r_addr = 14'd2; r_wdata = 16'h0000;
    @(negedge clk);
    l_wr = 0; r_wr = 0;
    expect_views("R11 no select", 14'd2, ONES, ONES);
  endtask

  task automatic t_tie;
    wr2(1, 14'd6, 16'h0000, 1, 14'd6, 16'h0000);
    expect_views("R9 tie left wins", 14'd6, ZERO, ONES);
    wl(14'd6, 16'h0001);
    expect_views("R9 right pending served", 14'd6, ONES, ZERO);
    wrt(14'd6, 16'h0001);
  endtask

  task automatic t_withdraw;
    wl(14'd7, 16'h0000);
    wrt(14'd7, 16'h0000);
    wrt(14'd7, 16'h0001);
    wl(14'd7, 16'h0001);
    expect_views("R13 withdrawn", 14'd7, ONES, ONES);
  endtask

  task automatic t_frozen;
    logic [DW-1:0] v;
    wrt(14'd3, 16'h0000);
    wl(14'd3, 16'h0000);
    @(negedge clk);
    l_sel = 1; l_oe = 1; l_addr = 14'd3;
    #1 chk("R8 first read", l_rdata, ONES);
    chk("R12 rdrive active", {15'd0, l_rdrive}, 16'd1);
    @(negedge clk);
    r_sel = 1; r_wr = 1; r_addr = 14'd3; r_wdata = 16'h0001;
    @(negedge clk);
    r_sel = 0; r_wr = 0;
    #1 chk("R8 frozen after handover", l_rdata, ONES);
    l_addr = 14'd0;
    @(negedge clk);
    #1 chk("R8 frozen after addr change", l_rdata, ONES);
    l_oe = 0;
    #1 chk("R12 oe low", l_rdata, ZERO);
    l_sel = 0;
    rd(0, 14'd3, v); chk("R8 R5 reread", v, ZERO);
    wl(14'd3, 16'h0001);
  endtask

  task automatic t_init;
    wl(14'd2, 16'h0000);
    wrt(14'd2, 16'h0000);
    wr2(1, 14'd2, 16'h0001, 1, 14'd2, 16'h0001);
    expect_views("R10 init both ones", 14'd2, ONES, ONES);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_claim();
    t_pending();
    t_addr();
    t_nosel();
    t_tie();
    t_withdraw();
    t_frozen();
    t_init();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule